// File: doc/BRIEF.md
# Codec Serial Port with Programmable Frame Sync

This block connects a slave audio codec to the rest of the chip. It runs on the bit clock. From it, the block divides out a frame-sync pulse whose period is set by a programmable divide-minus-one value, and that period sets the sample rate. For example, a 12.288 MHz bit clock divided by 1536, 768, 384, 256 or 128 gives 8, 16, 32, 48 or 96 kHz. Each frame carries one 16-bit sample in each direction. Both samples move in a short burst right after the frame-sync cycle, most significant bit first. For the rest of the frame the outgoing data line is released to high impedance. The tri-state buffer itself sits outside the block, on the output enable.

A DMA engine keeps the block fed. It receives a transmit-ready pulse each frame, when the queued sample is taken for the next frame, and a separate receive-valid pulse when a captured sample is available. Some rates do not divide evenly, such as 44.1 kHz. For these, the divide is rounded down and the surplus frames are covered by repetition. If nothing has been written to the transmit holding register by the start of a frame, the previously sent sample goes out again. Each such event is counted in a saturating underrun counter, and a clear strobe resets that counter. A period change written during a frame takes effect only at the next frame boundary.

Top module: `audio_serial_port`

## Requirements
- R1: A frame lasts exactly period_i + 1 bit-clock cycles, and fs_o is high for the single first cycle of each frame.
- R2: A change of period_i during a frame does not alter that frame's length; the value present at the end of a frame sets the length of the following frame.
- R3: A period value below 16 is handled as 16, which gives a 17-cycle frame, so a frame always has room for the 16-bit burst.
- R4: In the 16 cycles that follow the frame-sync cycle, sd_oe_o is high and sd_o carries the frame's transmit sample, bit 15 in the first cycle down to bit 0 in the sixteenth.
- R5: In every other cycle of the frame, including the frame-sync cycle, sd_oe_o is low and sd_o is 0.
- R6: sd_i is sampled at the clock edge that ends each of the 16 burst cycles, first bit as bit 15. In the cycle after the sixteenth burst cycle, rx_data_o holds the assembled word and rx_valid_o is high for exactly that one cycle.
- R7: tx_ready_o is high for exactly one cycle per frame, the frame-sync cycle. It marks the moment the holding register has been consumed and is free for the next sample.
- R8: A frame that starts without a tx_wr_i since the previous frame start transmits the previous frame's sample again, and urun_cnt_o then goes up by one, saturating at its maximum. A write in the cycle where a frame begins belongs to the following frame.
- R9: A cycle with urun_clr_i high sets urun_cnt_o to 0 on the next clock edge, taking priority over a coincident underrun.
- R10: While rst is high, fs_o, sd_oe_o, sd_o, tx_ready_o and rx_valid_o are 0 and urun_cnt_o is 0. The first frame starts on the first clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| period_i | input | PW (12) | Frame length minus one, in bit clocks |
| tx_data_i | input | SW (16) | Sample for the transmit holding register |
| tx_wr_i | input | 1 | Write strobe for tx_data_i |
| tx_ready_o | output | 1 | Transmit DMA event, one cycle per frame |
| sd_o | output | 1 | Serial data to the codec |
| sd_oe_o | output | 1 | Output enable for sd_o; low means high impedance |
| fs_o | output | 1 | Frame-sync pulse |
| sd_i | input | 1 | Serial data from the codec |
| rx_data_o | output | SW (16) | Last received sample |
| rx_valid_o | output | 1 | Receive DMA event, one cycle per sample |
| urun_clr_i | input | 1 | Clears the underrun counter |
| urun_cnt_o | output | UW (8) | Saturating count of repeated-sample frames |

## Verification
The bench sets the period to the minimum of 16, where the receive-valid pulse coincides with the next frame-sync cycle. A counter that wrapped one cycle early or late would show a frame length off by one, or a lost receive word. It changes the period in the middle of a frame; a design that loaded the period immediately would cut that frame short. It also writes a period below the minimum; without the clamp the burst would overlap the next frame sync. It stops refilling the holding register for two frames. A design that sent zeros or stale shift contents, or that failed to count the repeats, would show the wrong serial bits or the wrong underrun count. It also checks that a clear issued together with a write leaves the counter at zero.

// File: rtl/asp_pkg.sv
package asp_pkg;

    // Position of the bit clock inside a frame, produced by the frame timer.
    typedef struct packed {
        logic frame_end;  // last cycle of the frame; next edge starts a new one
        logic fs;         // frame-sync cycle
        logic burst;      // one of the data-bit cycles
        logic shift;      // a data-bit cycle that is followed by another
        logic last;       // final data-bit cycle
    } asp_phase_t;

    // Where the sample for a new frame comes from.
    typedef enum logic {
        SRC_FRESH  = 1'b0,
        SRC_REPEAT = 1'b1
    } tx_src_e;

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asp_frame_timer.sv
module asp_frame_timer
    import asp_pkg::*;
#(
    parameter int PW      = 12,
    parameter int SW      = 16,
    parameter int PER_RST = 255
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-1:0] period_i,
    output asp_phase_t    ph_o
);
    // Shortest legal period leaves the burst plus the sync cycle.
    localparam int MIN_PER = SW;
    // Reset parks the counter on a frame end that is clear of the burst window.
    localparam int RST_LIM = max_int(PER_RST, SW + 1);

    logic [PW-1:0] cnt_q;
    logic [PW-1:0] per_q;
    logic [PW-1:0] per_lim;
    logic          at_end;

    always_comb begin
        per_lim = (period_i < PW'(MIN_PER)) ? PW'(MIN_PER) : period_i;
        at_end  = (cnt_q == per_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= PW'(RST_LIM);
            per_q <= PW'(RST_LIM);
        end else if (at_end) begin
            cnt_q <= '0;
            per_q <= per_lim;
        end else begin
            cnt_q <= cnt_q + PW'(1);
        end
    end

    always_comb begin
        ph_o.frame_end = at_end;
        ph_o.fs        = (cnt_q == '0);
        ph_o.burst     = (cnt_q >= PW'(1)) && (cnt_q <= PW'(SW));
        ph_o.shift     = (cnt_q >= PW'(1)) && (cnt_q <  PW'(SW));
        ph_o.last      = (cnt_q == PW'(SW));
    end

endmodule

// File: rtl/asp_tx_path.sv
module asp_tx_path
    import asp_pkg::*;
#(
    parameter int SW = 16,
    parameter int UW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          frame_end_i,
    input  logic          burst_i,
    input  logic          shift_i,
    input  logic          wr_i,
    input  logic [SW-1:0] data_i,
    input  logic          clr_i,
    output logic          sd_o,
    output logic          oe_o,
    output logic          ready_o,
    output logic [UW-1:0] urun_o
);
    localparam logic [UW-1:0] URUN_MAX = {UW{1'b1}};

    logic [SW-1:0] hold_q;
    logic          full_q;
    logic [SW-1:0] prev_q;
    logic [SW-1:0] sh_q;
    logic          ready_q;
    logic [UW-1:0] urun_q;
    tx_src_e       src;
    logic [SW-1:0] next_word;

    always_comb begin
        src       = full_q ? SRC_FRESH : SRC_REPEAT;
        next_word = (src == SRC_FRESH) ? hold_q : prev_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q  <= '0;
            full_q  <= 1'b0;
            prev_q  <= '0;
            sh_q    <= '0;
            ready_q <= 1'b0;
            urun_q  <= '0;
        end else begin
            ready_q <= frame_end_i;
            if (frame_end_i) begin
                sh_q   <= next_word;
                prev_q <= next_word;
                full_q <= 1'b0;
            end else if (shift_i) begin
                sh_q <= {sh_q[SW-2:0], 1'b0};
            end
            // A write at the frame edge lands after the consume, so it
            // serves the following frame.
            if (wr_i) begin
                hold_q <= data_i;
                full_q <= 1'b1;
            end
            if (clr_i) begin
                urun_q <= '0;
            end else if (frame_end_i && (src == SRC_REPEAT) && (urun_q != URUN_MAX)) begin
                urun_q <= urun_q + UW'(1);
            end
        end
    end

    always_comb begin
        oe_o    = burst_i;
        sd_o    = burst_i & sh_q[SW-1];
        ready_o = ready_q;
        urun_o  = urun_q;
    end

endmodule

// File: rtl/asp_rx_path.sv
module asp_rx_path #(
    parameter int SW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          burst_i,
    input  logic          last_i,
    input  logic          sd_i,
    output logic [SW-1:0] data_o,
    output logic          valid_o
);
    logic [SW-1:0] sh_q;
    logic [SW-1:0] data_q;
    logic          valid_q;
    logic [SW-1:0] word_in;

    always_comb word_in = {sh_q[SW-2:0], sd_i};

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q    <= '0;
            data_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (burst_i) begin
                sh_q <= word_in;
            end
            if (last_i) begin
                data_q  <= word_in;
                valid_q <= 1'b1;
            end
        end
    end

    always_comb begin
        data_o  = data_q;
        valid_o = valid_q;
    end

endmodule

// File: rtl/audio_serial_port.sv
module audio_serial_port
    import asp_pkg::*;
#(
    parameter int PW      = 12,
    parameter int SW      = 16,
    parameter int UW      = 8,
    parameter int PER_RST = 255
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-1:0] period_i,
    input  logic [SW-1:0] tx_data_i,
    input  logic          tx_wr_i,
    output logic          tx_ready_o,
    output logic          sd_o,
    output logic          sd_oe_o,
    output logic          fs_o,
    input  logic          sd_i,
    output logic [SW-1:0] rx_data_o,
    output logic          rx_valid_o,
    input  logic          urun_clr_i,
    output logic [UW-1:0] urun_cnt_o
);
    asp_phase_t ph;

    asp_frame_timer #(
        .PW      (PW),
        .SW      (SW),
        .PER_RST (PER_RST)
    ) timer_i (
        .clk      (clk),
        .rst      (rst),
        .period_i (period_i),
        .ph_o     (ph)
    );

    asp_tx_path #(
        .SW (SW),
        .UW (UW)
    ) tx_i (
        .clk         (clk),
        .rst         (rst),
        .frame_end_i (ph.frame_end),
        .burst_i     (ph.burst),
        .shift_i     (ph.shift),
        .wr_i        (tx_wr_i),
        .data_i      (tx_data_i),
        .clr_i       (urun_clr_i),
        .sd_o        (sd_o),
        .oe_o        (sd_oe_o),
        .ready_o     (tx_ready_o),
        .urun_o      (urun_cnt_o)
    );

    asp_rx_path #(
        .SW (SW)
    ) rx_i (
        .clk     (clk),
        .rst     (rst),
        .burst_i (ph.burst),
        .last_i  (ph.last),
        .sd_i    (sd_i),
        .data_o  (rx_data_o),
        .valid_o (rx_valid_o)
    );

    always_comb fs_o = ph.fs;

endmodule

// File: rtl/asp_checker.sv
module asp_checker #(
    parameter int SW = 16,
    parameter int UW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          fs_o,
    input logic          sd_o,
    input logic          sd_oe_o,
    input logic          tx_ready_o,
    input logic          rx_valid_o,
    input logic          urun_clr_i,
    input logic [UW-1:0] urun_cnt_o
);
    // Length of the current run of enabled cycles.
    logic [7:0] oe_run;

    always_ff @(posedge clk) begin
        if (rst)          oe_run <= '0;
        else if (sd_oe_o) oe_run <= (oe_run == 8'hff) ? oe_run : oe_run + 8'd1;
        else              oe_run <= '0;
    end

    p_fs_single_r1: assert property (@(posedge clk) disable iff (rst)
        fs_o |=> !fs_o);

    p_fs_then_burst_r4: assert property (@(posedge clk) disable iff (rst)
        fs_o |=> sd_oe_o);

    p_burst_len_r4: assert property (@(posedge clk) disable iff (rst)
        int'(oe_run) <= SW);

    p_quiet_at_fs_r5: assert property (@(posedge clk) disable iff (rst)
        fs_o |-> !sd_oe_o);

    p_dout_idle_r5: assert property (@(posedge clk) disable iff (rst)
        !sd_oe_o |-> !sd_o);

    p_valid_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        rx_valid_o |=> !rx_valid_o);

    p_ready_on_fs_r7: assert property (@(posedge clk) disable iff (rst)
        tx_ready_o |-> fs_o);

    p_fs_has_ready_r7: assert property (@(posedge clk) disable iff (rst)
        fs_o |-> tx_ready_o);

    p_urun_monotonic_r8: assert property (@(posedge clk) disable iff (rst)
        !urun_clr_i |=> (urun_cnt_o >= $past(urun_cnt_o)));

    p_urun_clear_r9: assert property (@(posedge clk) disable iff (rst)
        urun_clr_i |=> (urun_cnt_o == '0));

endmodule

bind audio_serial_port asp_checker #(
    .SW (SW),
    .UW (UW)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .fs_o       (fs_o),
    .sd_o       (sd_o),
    .sd_oe_o    (sd_oe_o),
    .tx_ready_o (tx_ready_o),
    .rx_valid_o (rx_valid_o),
    .urun_clr_i (urun_clr_i),
    .urun_cnt_o (urun_cnt_o)
);

// File: tb/audio_serial_port_tb_top.sv
module audio_serial_port_tb_top;

    localparam int PW = 12;
    localparam int SW = 16;
    localparam int UW = 8;

    typedef struct packed {
        logic [PW-1:0] per;
        logic [SW-1:0] tx;
        logic [SW-1:0] rx;
    } vec_t;

    localparam int NVEC = 5;
    localparam vec_t VEC [NVEC] = '{
        '{12'd31, 16'hA5CF, 16'h3C96},
        '{12'd16, 16'h8001, 16'hFFFE},
        '{12'd63, 16'h0000, 16'h5AA5},
        '{12'd20, 16'hFFFF, 16'h8000},
        '{12'd17, 16'h1234, 16'h0001}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [PW-1:0] period_i = 12'd31;
    logic [SW-1:0] tx_data_i = '0;
    logic          tx_wr_i = 1'b0;
    logic          tx_ready_o;
    logic          sd_o;
    logic          sd_oe_o;
    logic          fs_o;
    logic          sd_i = 1'b0;
    logic [SW-1:0] rx_data_o;
    logic          rx_valid_o;
    logic          urun_clr_i = 1'b0;
    logic [UW-1:0] urun_cnt_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    audio_serial_port #(
        .PW (PW),
        .SW (SW),
        .UW (UW)
    ) dut_i (
        .clk        (clk),
        .rst        (rst),
        .period_i   (period_i),
        .tx_data_i  (tx_data_i),
        .tx_wr_i    (tx_wr_i),
        .tx_ready_o (tx_ready_o),
        .sd_o       (sd_o),
        .sd_oe_o    (sd_oe_o),
        .fs_o       (fs_o),
        .sd_i       (sd_i),
        .rx_data_o  (rx_data_o),
        .rx_valid_o (rx_valid_o),
        .urun_clr_i (urun_clr_i),
        .urun_cnt_o (urun_cnt_o)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Advance to the next negedge where fs_o is high.
    task automatic sync_fs();
        do @(negedge clk); while (!fs_o);
    endtask

    // From a frame-sync negedge, count cycles up to the next frame sync.
    task automatic frame_len(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!fs_o);
    endtask

    // Called at the negedge of a frame-sync cycle; returns at the next one.
    task automatic run_frame(input logic [SW-1:0] tx, input logic [SW-1:0] rx, input int exp_len);
        int  n;
        bit  leak;
        chk(tx_ready_o == 1'b1, "R7 ready in sync cycle", 32'(tx_ready_o), 32'd1);
        chk(sd_oe_o == 1'b0, "R5 no drive in sync cycle", 32'(sd_oe_o), 32'd0);
        for (int k = SW - 1; k >= 0; k--) begin
            @(negedge clk);
            chk(sd_oe_o == 1'b1 && sd_o == tx[k], "R4 burst bit",
                {sd_oe_o, 15'd0, 15'd0, sd_o}, {1'b1, 15'd0, 15'd0, tx[k]});
            chk(tx_ready_o == 1'b0, "R7 ready single cycle", 32'(tx_ready_o), 32'd0);
            sd_i = rx[k];
        end
        @(negedge clk);
        n = SW + 1;
        chk(rx_valid_o == 1'b1 && rx_data_o == rx, "R6 received word",
            {15'd0, rx_valid_o, rx_data_o}, {15'd0, 1'b1, rx});
        leak = sd_oe_o | sd_o;
        while (!fs_o) begin
            @(negedge clk);
            n++;
            leak |= (sd_oe_o | sd_o);
        end
        chk(leak == 1'b0, "R5 line released after burst", 32'(leak), 32'd0);
        chk(n == exp_len, "R1 frame length", 32'(n), 32'(exp_len));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        int n;
        // R10: outputs quiet while reset is held.
        repeat (3) @(negedge clk);
        chk(fs_o == 1'b0 && sd_oe_o == 1'b0 && sd_o == 1'b0, "R10 reset line state",
            {29'd0, fs_o, sd_oe_o, sd_o}, 32'd0);
        chk(tx_ready_o == 1'b0 && rx_valid_o == 1'b0, "R10 reset events",
            {30'd0, tx_ready_o, rx_valid_o}, 32'd0);
        chk(urun_cnt_o == '0, "R10 reset underrun count", 32'(urun_cnt_o), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(fs_o == 1'b1, "R10 first frame on release", 32'(fs_o), 32'd1);

        // Vector table: each entry sets the period and the sample for one frame.
        for (int i = 0; i < NVEC; i++) begin
            period_i  = VEC[i].per;
            tx_data_i = VEC[i].tx;
            tx_wr_i   = 1'b1;
            @(negedge clk);
            tx_wr_i = 1'b0;
            sync_fs();
            run_frame(VEC[i].tx, VEC[i].rx, int'(VEC[i].per) + 1);
        end

        // R8/R9: clear together with a write, then stop refilling.
        period_i   = 12'd20;
        urun_clr_i = 1'b1;
        tx_data_i  = 16'hC3A5;
        tx_wr_i    = 1'b1;
        @(negedge clk);
        urun_clr_i = 1'b0;
        tx_wr_i    = 1'b0;
        chk(urun_cnt_o == '0, "R9 clear wins over underrun", 32'(urun_cnt_o), 32'd0);
        sync_fs();
        chk(urun_cnt_o == '0, "R8 no underrun after write", 32'(urun_cnt_o), 32'd0);
        run_frame(16'hC3A5, 16'h0F0F, 21);
        chk(urun_cnt_o == 8'd1, "R8 first underrun counted", 32'(urun_cnt_o), 32'd1);
        run_frame(16'hC3A5, 16'hF00F, 21);   // R8: previous sample repeated
        chk(urun_cnt_o == 8'd2, "R8 second underrun counted", 32'(urun_cnt_o), 32'd2);

        // R2: period changed in mid-frame applies to the next frame only.
        n = 0;
        repeat (5) begin
            @(negedge clk);
            n++;
        end
        period_i = 12'd40;
        while (!fs_o) begin
            @(negedge clk);
            n++;
        end
        chk(n == 21, "R2 current frame keeps old period", 32'(n), 32'd21);
        frame_len(n);
        chk(n == 41, "R2 next frame uses new period", 32'(n), 32'd41);

        // R3: a period below the minimum is raised to 16.
        period_i = 12'd3;
        frame_len(n);
        chk(n == 41, "R2 frame before clamp unaffected", 32'(n), 32'd41);
        run_frame(16'hC3A5, 16'h6969, 17);   // R3 clamped frame, burst intact
        frame_len(n);
        chk(n == 17, "R3 clamped frame length", 32'(n), 32'd17);

        // R9: clear after counting.
        urun_clr_i = 1'b1;
        @(negedge clk);
        urun_clr_i = 1'b0;
        chk(urun_cnt_o == '0, "R9 counter cleared", 32'(urun_cnt_o), 32'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule